// File: doc/BRIEF.md
# Calibrated One-Second Tick Prescaler

This block turns a slow real-time reference clock into a one-cycle pulse once per second, for use by a calendar counter. A divider counts `PERIOD` reference clocks per second. The default is 32768, which suits a 32.768 kHz crystal. The clock-control register of the owning block supplies three controls that reach this block as separate inputs: a run enable, a divider clear, and a bypass that turns correction off.

Crystal drift is trimmed by a correction counter that counts finished seconds. Once it has counted the programmed interval, the following second is made one reference clock longer or one clock shorter, according to a direction input. The counter then starts over. A correction interval of zero behaves like the bypass input.

Top module: `tick_prescaler`

## Requirements
- R1: While `rst_ni` is low, `tick_o` is low and both internal counters are zero. After release, with run enabled and correction inactive, the first tick appears `PERIOD` clocks after the first rising edge.
- R2: With `run_en_i` high, `div_clr_i` low and correction inactive, `tick_o` pulses high for exactly one clock every `PERIOD` clocks.
- R3: While `run_en_i` is low, no tick is produced and the divider holds its count. Setting `run_en_i` again resumes the count from where it stopped.
- R4: While `div_clr_i` is high, no tick is produced and both the divider and the correction counter are held at zero. This holds whatever the state of `run_en_i`.
- R5: While `cal_bypass_i` is high, every second is `PERIOD` clocks long and the correction counter stays at zero.
- R6: A `cal_interval_i` of zero disables correction exactly as `cal_bypass_i` does.
- R7: With an interval N of 1 or more, the correction counter counts ticks. The second that follows the N-th tick is corrected, and that corrected second is also the first of the next group. So, counting from a cleared state, seconds N+1, 2N+1, 3N+1 and so on are corrected.
- R8: A corrected second lasts `PERIOD`+1 clocks when `cal_lengthen_i` is 1, and `PERIOD`-1 clocks when it is 0.
- R9: Pulsing `div_clr_i` part-way through a correction group restarts the sequence. The next N seconds after release are nominal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock (crystal rate) |
| rst_ni | input | 1 | Asynchronous active-low reset |
| run_en_i | input | 1 | Counting enable from the clock-control register |
| div_clr_i | input | 1 | Holds the divider and the correction counter cleared |
| cal_bypass_i | input | 1 | Disables correction |
| cal_interval_i | input | CAL_W | Correction interval N, in seconds |
| cal_lengthen_i | input | 1 | 1 lengthens corrected seconds, 0 shortens them |
| tick_o | output | 1 | One-clock pulse per second |

## Verification
The hardest case to reach is a divider clear that lands in the middle of a correction group while the divider itself is part-way through a second. Only the spacing of later ticks shows whether both counters restarted. To reach it, the stimulus programs an interval of 3, lets two ticks pass, and clears at a mid-second point. It then checks that the next three seconds are nominal and that the fourth is lengthened. A divider that was not cleared would shift the first spacing, and a correction counter that was not cleared would stretch the second spacing. The same spacing method covers a pause of the run enable, which must resume the count exactly where it stopped.

// File: rtl/tick_pre_pkg.sv
package tick_pre_pkg;

  typedef enum logic [1:0] {
    LEN_NOM   = 2'd0,
    LEN_LONG  = 2'd1,
    LEN_SHORT = 2'd2
  } len_sel_e;

  typedef struct packed {
    logic run;      // divider advances this cycle
    logic clr;      // divider and correction counter forced to zero
    logic cal_on;   // correction active
    logic lengthen; // direction of correction
  } ctl_t;

endpackage

// File: rtl/tick_pre_dec.sv
module tick_pre_dec #(
  parameter int CAL_W = 17
) (
  input  logic                 run_en_i,
  input  logic                 div_clr_i,
  input  logic                 cal_bypass_i,
  input  logic [CAL_W-1:0]     cal_interval_i,
  input  logic                 cal_lengthen_i,
  output tick_pre_pkg::ctl_t   ctl_o
);

  always_comb begin
    ctl_o.clr      = div_clr_i;
    ctl_o.run      = run_en_i & ~div_clr_i;
    ctl_o.cal_on   = ~cal_bypass_i & (cal_interval_i != '0);
    ctl_o.lengthen = cal_lengthen_i;
  end

endmodule

// File: rtl/tick_pre_div.sv
module tick_pre_div #(
  parameter int PERIOD = 32768,
  parameter int CNT_W  = $clog2(PERIOD + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   clr_i,
  input  logic                   run_i,
  input  tick_pre_pkg::len_sel_e len_sel_i,
  output logic                   term_o,
  output logic                   tick_o,
  output logic [CNT_W-1:0]       cnt_o
);
  import tick_pre_pkg::*;

  localparam logic [CNT_W-1:0] LAST_NOM   = CNT_W'(PERIOD - 1);
  localparam logic [CNT_W-1:0] LAST_LONG  = CNT_W'(PERIOD);
  localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(PERIOD - 2);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;
  logic             tick_q;

  always_comb begin
    unique case (len_sel_i)
      LEN_LONG:  last = LAST_LONG;
      LEN_SHORT: last = LAST_SHORT;
      default:   last = LAST_NOM;
    endcase
  end

  // >= so a late switch to the short length cannot overrun
  assign term_o = run_i & (cnt_q >= last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else if (run_i) begin
      tick_q <= term_o;
      cnt_q  <= term_o ? '0 : cnt_q + 1'b1;
    end else begin
      tick_q <= 1'b0;
    end
  end

  assign tick_o = tick_q;
  assign cnt_o  = cnt_q;

endmodule

// File: rtl/tick_pre_cal.sv
module tick_pre_cal #(
  parameter int CAL_W = 17
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   clr_i,
  input  logic                   cal_on_i,
  input  logic                   step_i,
  input  logic [CAL_W-1:0]       interval_i,
  input  logic                   lengthen_i,
  output tick_pre_pkg::len_sel_e len_sel_o,
  output logic [CAL_W-1:0]       cnt_o
);
  import tick_pre_pkg::*;

  logic [CAL_W-1:0] cnt_q;
  logic             adj_q;
  logic [CAL_W:0]   cnt_nxt;

  assign cnt_nxt = {1'b0, cnt_q} + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      adj_q <= 1'b0;
    end else if (clr_i || !cal_on_i) begin
      cnt_q <= '0;
      adj_q <= 1'b0;
    end else if (step_i) begin
      // >= tolerates the interval being lowered mid-group
      if (cnt_nxt >= {1'b0, interval_i}) begin
        cnt_q <= '0;
        adj_q <= 1'b1;
      end else begin
        cnt_q <= cnt_nxt[CAL_W-1:0];
        adj_q <= 1'b0;
      end
    end
  end

  always_comb begin
    if (!adj_q)          len_sel_o = LEN_NOM;
    else if (lengthen_i) len_sel_o = LEN_LONG;
    else                 len_sel_o = LEN_SHORT;
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
  parameter int PERIOD = 32768,
  parameter int CAL_W  = 17
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_en_i,
  input  logic             div_clr_i,
  input  logic             cal_bypass_i,
  input  logic [CAL_W-1:0] cal_interval_i,
  input  logic             cal_lengthen_i,
  output logic             tick_o
);
  import tick_pre_pkg::*;

  localparam int CNT_W = $clog2(PERIOD + 1);

  ctl_t             ctl;
  len_sel_e         len_sel;
  logic             term;
  logic [CNT_W-1:0] div_cnt;
  logic [CAL_W-1:0] cal_cnt;

  tick_pre_dec #(.CAL_W(CAL_W)) u_dec (
    .run_en_i       (run_en_i),
    .div_clr_i      (div_clr_i),
    .cal_bypass_i   (cal_bypass_i),
    .cal_interval_i (cal_interval_i),
    .cal_lengthen_i (cal_lengthen_i),
    .ctl_o          (ctl)
  );

  tick_pre_div #(.PERIOD(PERIOD), .CNT_W(CNT_W)) u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (ctl.clr),
    .run_i     (ctl.run),
    .len_sel_i (len_sel),
    .term_o    (term),
    .tick_o    (tick_o),
    .cnt_o     (div_cnt)
  );

  tick_pre_cal #(.CAL_W(CAL_W)) u_cal (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (ctl.clr),
    .cal_on_i   (ctl.cal_on),
    .step_i     (term),
    .interval_i (cal_interval_i),
    .lengthen_i (ctl.lengthen),
    .len_sel_o  (len_sel),
    .cnt_o      (cal_cnt)
  );

endmodule

// File: rtl/tick_prescaler_chk.sv
module tick_prescaler_chk #(
  parameter int PERIOD = 32768,
  parameter int CAL_W  = 17,
  parameter int CNT_W  = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             run_en_i,
  input logic             div_clr_i,
  input logic             cal_bypass_i,
  input logic [CAL_W-1:0] cal_interval_i,
  input logic             tick_o,
  input logic [CNT_W-1:0] div_cnt,
  input logic [CAL_W-1:0] cal_cnt
);

  // R2
  single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);

  // R2
  div_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_cnt <= CNT_W'(PERIOD));

  // R3
  idle_no_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_en_i |=> !tick_o);

  // R3
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_en_i && !div_clr_i) |=> $stable(div_cnt));

  // R4
  clr_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_clr_i |=> (div_cnt == '0 && cal_cnt == '0 && !tick_o));

  // R5
  bypass_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_bypass_i |=> cal_cnt == '0);

  // R6
  zero_interval_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cal_interval_i == '0) |=> cal_cnt == '0);

endmodule

bind tick_prescaler tick_prescaler_chk #(
  .PERIOD (PERIOD),
  .CAL_W  (CAL_W),
  .CNT_W  (CNT_W)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .run_en_i       (run_en_i),
  .div_clr_i      (div_clr_i),
  .cal_bypass_i   (cal_bypass_i),
  .cal_interval_i (cal_interval_i),
  .tick_o         (tick_o),
  .div_cnt        (div_cnt),
  .cal_cnt        (cal_cnt)
);

// File: tb/tick_prescaler_tb.sv
module tick_prescaler_tb;
  localparam int P     = 8;
  localparam int CW    = 17;
  localparam int SLOTS = 7;
  localparam int NV    = 9;

  typedef struct packed {
    logic                   en;
    logic                   clr;
    logic                   byp;
    logic                   lng;
    logic [CW-1:0]          n;
    logic [SLOTS-1:0][4:0]  len; // len[0] = first second; 0 = no tick
  } vec_t;

  // lengths listed last-second first
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 1'b0, 1'b1, 17'd0,       {5'd8, 5'd8, 5'd8, 5'd8, 5'd8, 5'd8, 5'd8}},
    '{1'b1, 1'b0, 1'b1, 1'b1, 17'd2,       {5'd8, 5'd8, 5'd8, 5'd8, 5'd8, 5'd8, 5'd8}},
    '{1'b1, 1'b0, 1'b0, 1'b1, 17'd3,       {5'd9, 5'd8, 5'd8, 5'd9, 5'd8, 5'd8, 5'd8}},
    '{1'b1, 1'b0, 1'b0, 1'b0, 17'd3,       {5'd7, 5'd8, 5'd8, 5'd7, 5'd8, 5'd8, 5'd8}},
    '{1'b1, 1'b0, 1'b0, 1'b0, 17'd1,       {5'd7, 5'd7, 5'd7, 5'd7, 5'd7, 5'd7, 5'd8}},
    '{1'b1, 1'b0, 1'b0, 1'b1, 17'd2,       {5'd9, 5'd8, 5'd9, 5'd8, 5'd9, 5'd8, 5'd8}},
    '{1'b0, 1'b0, 1'b0, 1'b1, 17'd0,       {5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0}},
    '{1'b1, 1'b1, 1'b0, 1'b1, 17'd1,       {5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0}},
    '{1'b1, 1'b0, 1'b0, 1'b1, 17'h1ffff,   {5'd8, 5'd8, 5'd8, 5'd8, 5'd8, 5'd8, 5'd8}}
  };
  localparam string TAGS [NV] = '{"R6", "R5", "R8", "R8", "R7", "R7", "R3", "R4", "R2"};

  logic          clk = 1'b0;
  logic          rst_ni;
  logic          run_en_i, div_clr_i, cal_bypass_i, cal_lengthen_i;
  logic [CW-1:0] cal_interval_i;
  logic          tick_o;

  int n_chk = 0;
  int n_bad = 0;
  int got [SLOTS];

  always #4 clk = ~clk;

  tick_prescaler #(.PERIOD(P), .CAL_W(CW)) u_dut (
    .clk_i          (clk),
    .rst_ni         (rst_ni),
    .run_en_i       (run_en_i),
    .div_clr_i      (div_clr_i),
    .cal_bypass_i   (cal_bypass_i),
    .cal_interval_i (cal_interval_i),
    .cal_lengthen_i (cal_lengthen_i),
    .tick_o         (tick_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // clear for two cycles, then release at a falling edge
  task automatic restart(input logic en, input logic clr, input logic byp,
                         input logic lng, input logic [CW-1:0] n);
    @(negedge clk);
    run_en_i = en; div_clr_i = 1'b1; cal_bypass_i = byp;
    cal_lengthen_i = lng; cal_interval_i = n;
    repeat (2) @(negedge clk);
    div_clr_i = clr;
  endtask

  task automatic collect(input int cycles);
    int last = 0;
    int k = 0;
    for (int s = 0; s < SLOTS; s++) got[s] = 0;
    for (int c = 1; c <= cycles; c++) begin
      @(negedge clk);
      if (tick_o && k < SLOTS) begin
        got[k] = c - last;
        last = c;
        k++;
      end
    end
  endtask

  initial begin
    #(8 * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL R2 watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int first;
    bit seen;
    rst_ni = 1'b0; run_en_i = 1'b1; div_clr_i = 1'b0; cal_bypass_i = 1'b0;
    cal_lengthen_i = 1'b1; cal_interval_i = '0;
    repeat (3) @(negedge clk);
    chk(tick_o == 1'b0, "R1 reset", int'(tick_o), 0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      restart(VECS[i].en, VECS[i].clr, VECS[i].byp, VECS[i].lng, VECS[i].n);
      collect(75);
      for (int s = 0; s < SLOTS; s++)
        chk(got[s] == int'(VECS[i].len[s]), TAGS[i], got[s], int'(VECS[i].len[s]));
    end

    // R3: pause mid-second, resume from the held count
    restart(1'b1, 1'b0, 1'b0, 1'b1, '0);
    repeat (5) @(negedge clk);
    run_en_i = 1'b0;
    seen = 1'b0;
    repeat (10) begin
      @(negedge clk);
      if (tick_o) seen = 1'b1;
    end
    chk(!seen, "R3 paused", int'(seen), 0);
    run_en_i = 1'b1;
    first = 0;
    for (int c = 1; c <= 12; c++) begin
      @(negedge clk);
      if (tick_o && first == 0) first = c;
    end
    chk(first == 3, "R3 resume", first, 3);

    // R9 / R4: clear mid-group and mid-second
    restart(1'b1, 1'b0, 1'b0, 1'b1, 17'd3);
    repeat (20) @(negedge clk);
    div_clr_i = 1'b1;
    repeat (2) @(negedge clk);
    div_clr_i = 1'b0;
    collect(40);
    chk(got[0] == P, "R4 divider cleared", got[0], P);
    chk(got[1] == P, "R9 restart", got[1], P);
    chk(got[2] == P, "R9 restart", got[2], P);
    chk(got[3] == P + 1, "R9 restart", got[3], P + 1);

    // R1: asynchronous reset mid-second
    restart(1'b1, 1'b0, 1'b0, 1'b1, '0);
    repeat (4) @(negedge clk);
    #1 rst_ni = 1'b0;
    #1 chk(tick_o == 1'b0, "R1 async", int'(tick_o), 0);
    @(negedge clk);
    rst_ni = 1'b1;
    collect(20);
    chk(got[0] == P, "R1 restart", got[0], P);
    chk(got[1] == P, "R2 period", got[1], P);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule